// File: doc/BRIEF.md
# 64-bit Rotate-and-Mask Unit

This unit executes the immediate-form doubleword rotate group. That group has three members: rotate then clear on the left, rotate then clear on the right, and rotate then insert under a mask. Each cycle the unit may receive one 32-bit instruction word, the source register value and the current value of the destination register. The insert form needs the destination value because it keeps part of it. The unit takes the 6-bit shift amount and the 6-bit mask bound from their split positions in the word and rotates the source left. It then builds the mask for the selected form, merges the result and registers everything in a single output stage. When the record bit is set, it also produces the four condition bits (less, greater, equal, summary overflow). The register file, hazards and trap delivery stay outside the unit. A word that cannot execute is reported on a fault output.

The output stage is a three-state slot. The states are SLOT_EMPTY (nothing to deliver), SLOT_RESULT (a result with write enable) and SLOT_FAULT (a rejected word). Every clock the slot takes a new state from the current inputs:
- it goes to SLOT_EMPTY when no word is issued;
- it goes to SLOT_FAULT when the issued word is rejected;
- it goes to SLOT_RESULT otherwise.

Any state can reach any other state in one cycle. Reset forces SLOT_EMPTY.

Top module: `rotm_unit`

## Requirements
- R1: While reset is asserted and after it is released with no issue, wr_en, fault, rec_flag, cr0 and result are all zero.
- R2: The shift amount is {insn[1], insn[15:11]}. The mask bound is {insn[5], insn[10:6]}. src_idx shows insn[25:21] and dst_idx shows insn[20:16] of the word presented one cycle earlier.
- R3: A legal issued word raises wr_en in the cycle after issue, with the result. A cycle without issue leaves wr_en and fault low in the next cycle.
- R4: Sub-opcode insn[4:2]=0 (clear-left): the result is the source rotated left by the shift amount (bits leaving bit 63 re-enter at bit 0). It is ANDed with a mask covering big-endian positions bound..63, where position m is bit 63-m.
- R5: Sub-opcode 1 (clear-right): the bound field is the mask end, and the mask covers positions 0..bound.
- R6: Sub-opcode 3 (insert): the mask covers positions bound..(63 - shift). Bits inside the mask take the rotated source. Bits outside keep dst_old.
- R7: When the mask begin exceeds the mask end, the mask is the union of positions begin..63 and 0..end.
- R8: Sub-opcodes 2 and 4..7, and any word whose primary field insn[31:26] is not 30, raise fault in the next cycle with wr_en, rec_flag, cr0 and result at zero.
- R9: An issued word while mode32 is high raises fault and never wr_en, whatever its encoding.
- R10: When insn[0] is set on a legal word, rec_flag rises with wr_en and cr0[3:0] = {LT, GT, EQ, SO}. LT, GT and EQ come from a signed comparison of the 64-bit result with zero, and SO copies so_in. Without the record bit, cr0 is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| dst_old | input | 64 | Current destination register value |
| mode32 | input | 1 | Processor is in 32-bit mode |
| so_in | input | 1 | Summary-overflow bit copied into cr0 |
| wr_en | output | 1 | Destination write enable |
| fault | output | 1 | Word rejected |
| rec_flag | output | 1 | Condition field update requested |
| cr0 | output | 4 | {LT, GT, EQ, SO} |
| result | output | 64 | Value to write |
| src_idx | output | 5 | Source register index |
| dst_idx | output | 5 | Destination register index |

## Verification
The bench builds the unit with its default data width of 64, so the shift and bound fields are a full six bits. Rotations of 32 and more, and bounds in the upper half of the word, are therefore both reachable. The split most significant bits in insn[1] and insn[5] get directed cases of their own, and so do insert masks that wrap around when the bound passes 63 minus the shift. Random words mixing the three forms, rejected sub-opcodes and 32-bit mode are then compared every cycle against a behavioural model.

// File: rtl/rotm_pkg.sv
package rotm_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR_LEFT,
        OP_CLEAR_RIGHT,
        OP_INSERT,
        OP_BAD
    } rot_op_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY,
        SLOT_RESULT,
        SLOT_FAULT
    } slot_e;

    localparam logic [5:0] PRIM_GROUP = 6'd30;
    localparam logic [2:0] SUB_CLEAR_LEFT  = 3'd0;
    localparam logic [2:0] SUB_CLEAR_RIGHT = 3'd1;
    localparam logic [2:0] SUB_INSERT      = 3'd3;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

endpackage

// File: rtl/rotm_decode.sv
module rotm_decode
    import rotm_pkg::*;
#(
    parameter int IW   = 32,
    parameter int SHW  = 6,
    parameter int RIDW = 5
) (
    input  logic [IW-1:0]   word,
    output logic [SHW-1:0]  shamt,
    output logic [SHW-1:0]  bound,
    output logic [RIDW-1:0] rs_sel,
    output logic [RIDW-1:0] rd_sel,
    output rot_op_e         op,
    output logic            rec_bit
);
    logic [2:0] sub;
    logic       prim_ok;

    always_comb begin
        shamt   = {word[1], word[15:11]};
        bound   = {word[5], word[10:6]};
        rs_sel  = word[25:21];
        rd_sel  = word[20:16];
        rec_bit = word[0];
        sub     = word[4:2];
        prim_ok = (word[31:26] == PRIM_GROUP);
    end

    always_comb begin
        op = OP_BAD;
        if (prim_ok) begin
            unique case (sub)
                SUB_CLEAR_LEFT:  op = OP_CLEAR_LEFT;
                SUB_CLEAR_RIGHT: op = OP_CLEAR_RIGHT;
                SUB_INSERT:      op = OP_INSERT;
                default:         op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/rotm_rotator.sv
module rotm_rotator #(
    parameter int DW = 64,
    localparam int SHW = $clog2(DW)
) (
    input  logic [DW-1:0]  din,
    input  logic [SHW-1:0] amt,
    output logic [DW-1:0]  dout
);
    logic [DW-1:0] stage [SHW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][DW-1-STEP:0], stage[k][DW-1 -: STEP]}
            : stage[k];
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/rotm_maskgen.sv
module rotm_maskgen #(
    parameter int DW = 64,
    localparam int SHW = $clog2(DW)
) (
    input  logic [SHW-1:0] first_pos,
    input  logic [SHW-1:0] last_pos,
    output logic [DW-1:0]  mask
);
    logic wraps;

    assign wraps = (first_pos > last_pos);

    for (genvar p = 0; p < DW; p++) begin : g_pos
        localparam logic [SHW-1:0] POS = SHW'(p);
        logic ge_first;
        logic le_last;
        assign ge_first = (POS >= first_pos);
        assign le_last  = (POS <= last_pos);
        assign mask[DW-1-p] = wraps ? (ge_first | le_last)
                                    : (ge_first & le_last);
    end
endmodule

// File: rtl/rotm_unit.sv
module rotm_unit
    import rotm_pkg::*;
#(
    parameter int DW   = 64,
    parameter int IW   = 32,
    parameter int RIDW = 5,
    localparam int SHW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [IW-1:0]   insn,
    input  logic [DW-1:0]   src_val,
    input  logic [DW-1:0]   dst_old,
    input  logic            mode32,
    input  logic            so_in,
    output logic            wr_en,
    output logic            fault,
    output logic            rec_flag,
    output logic [3:0]      cr0,
    output logic [DW-1:0]   result,
    output logic [RIDW-1:0] src_idx,
    output logic [RIDW-1:0] dst_idx
);
    localparam logic [SHW-1:0] TOP_POS = SHW'(DW - 1);

    logic [SHW-1:0]  shamt;
    logic [SHW-1:0]  bound;
    logic [RIDW-1:0] rs_sel;
    logic [RIDW-1:0] rd_sel;
    rot_op_e         op;
    logic            rec_bit;

    logic [SHW-1:0]  first_pos;
    logic [SHW-1:0]  last_pos;
    logic [DW-1:0]   rotated;
    logic [DW-1:0]   mask;
    logic [DW-1:0]   merged;
    logic            reject;
    cr_field_t       cr_nx;

    slot_e           slot_q;
    slot_e           slot_nx;
    logic [DW-1:0]   res_q;
    cr_field_t       cr_q;
    logic            rec_q;
    logic [RIDW-1:0] src_q;
    logic [RIDW-1:0] dst_q;

    rotm_decode #(.IW(IW), .SHW(SHW), .RIDW(RIDW)) u_dec (
        .word    (insn),
        .shamt   (shamt),
        .bound   (bound),
        .rs_sel  (rs_sel),
        .rd_sel  (rd_sel),
        .op      (op),
        .rec_bit (rec_bit)
    );

    rotm_rotator #(.DW(DW)) u_rot (
        .din  (src_val),
        .amt  (shamt),
        .dout (rotated)
    );

    always_comb begin
        first_pos = '0;
        last_pos  = TOP_POS;
        unique case (op)
            OP_CLEAR_LEFT: begin
                first_pos = bound;
                last_pos  = TOP_POS;
            end
            OP_CLEAR_RIGHT: begin
                first_pos = '0;
                last_pos  = bound;
            end
            OP_INSERT: begin
                first_pos = bound;
                last_pos  = TOP_POS - shamt;
            end
            OP_BAD: begin
                first_pos = '0;
                last_pos  = TOP_POS;
            end
        endcase
    end

    rotm_maskgen #(.DW(DW)) u_mask (
        .first_pos (first_pos),
        .last_pos  (last_pos),
        .mask      (mask)
    );

    always_comb begin
        if (op == OP_INSERT) begin
            merged = (rotated & mask) | (dst_old & ~mask);
        end else begin
            merged = rotated & mask;
        end
        cr_nx.lt = merged[DW-1];
        cr_nx.eq = (merged == '0);
        cr_nx.gt = ~merged[DW-1] & (merged != '0);
        cr_nx.so = so_in;
        reject   = mode32 | (op == OP_BAD);
    end

    always_comb begin
        if (!issue) begin
            slot_nx = SLOT_EMPTY;
        end else if (reject) begin
            slot_nx = SLOT_FAULT;
        end else begin
            slot_nx = SLOT_RESULT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            slot_q <= slot_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            cr_q  <= '0;
            rec_q <= 1'b0;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            src_q <= rs_sel;
            dst_q <= rd_sel;
            if (slot_nx == SLOT_RESULT) begin
                res_q <= merged;
                cr_q  <= cr_nx;
                rec_q <= rec_bit;
            end else begin
                res_q <= '0;
                cr_q  <= '0;
                rec_q <= 1'b0;
            end
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        fault    = 1'b0;
        rec_flag = 1'b0;
        cr0      = '0;
        result   = '0;
        unique case (slot_q)
            SLOT_EMPTY: begin
                wr_en = 1'b0;
            end
            SLOT_RESULT: begin
                wr_en    = 1'b1;
                result   = res_q;
                rec_flag = rec_q;
                cr0      = rec_q ? cr_q : 4'b0000;
            end
            SLOT_FAULT: begin
                fault = 1'b1;
            end
            default: begin
                fault = 1'b0;
            end
        endcase
        src_idx = src_q;
        dst_idx = dst_q;
    end
endmodule

// File: rtl/rotm_checker.sv
module rotm_checker #(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue,
    input logic [IW-1:0] insn,
    input logic          mode32,
    input logic          wr_en,
    input logic          fault,
    input logic          rec_flag,
    input logic [3:0]    cr0,
    input logic [DW-1:0] result
);
    logic legal_word;

    assign legal_word = (insn[31:26] == 6'd30) &&
                        ((insn[4:2] == 3'd0) || (insn[4:2] == 3'd1) ||
                         (insn[4:2] == 3'd3));

    assert_issue_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !mode32 && legal_word) |=> (wr_en && !fault));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!wr_en && !fault));

    assert_bad_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !legal_word) |=> (fault && !wr_en));

    assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (result == '0 && !rec_flag && cr0 == 4'b0000));

    assert_mode32_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && mode32) |=> (fault && !wr_en));

    assert_rec_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_flag |-> (wr_en && $countones(cr0[3:1]) == 1));

    assert_rec_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_flag |-> (cr0[1] == (result == '0)));

    assert_cr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_flag |-> (cr0 == 4'b0000));
endmodule

bind rotm_unit rotm_checker #(.DW(DW), .IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .insn     (insn),
    .mode32   (mode32),
    .wr_en    (wr_en),
    .fault    (fault),
    .rec_flag (rec_flag),
    .cr0      (cr0),
    .result   (result)
);

// File: tb/sim_rotm_unit.sv
module sim_rotm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] src_val = '0;
    logic [63:0] dst_old = '0;
    logic        mode32 = 1'b0;
    logic        so_in = 1'b0;
    logic        wr_en, fault, rec_flag;
    logic [3:0]  cr0;
    logic [63:0] result;
    logic [4:0]  src_idx, dst_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rotm_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
        .src_val(src_val), .dst_old(dst_old), .mode32(mode32), .so_in(so_in),
        .wr_en(wr_en), .fault(fault), .rec_flag(rec_flag), .cr0(cr0),
        .result(result), .src_idx(src_idx), .dst_idx(dst_idx)
    );

    typedef struct {
        logic        wr;
        logic        flt;
        logic        rec;
        logic [3:0]  cr;
        logic [63:0] res;
        logic [4:0]  src;
        logic [4:0]  dst;
        string       tag;
    } exp_t;

    exp_t pend;
    bit   have_pend = 0;

    function automatic logic [31:0] mk(input int sub, input int sh,
                                       input int fld, input int rs,
                                       input int ra, input int rc);
        logic [31:0] w = '0;
        w[31:26] = 6'd30;
        w[25:21] = rs[4:0];
        w[20:16] = ra[4:0];
        w[15:11] = sh[4:0];
        w[10:6]  = fld[4:0];
        w[5]     = fld[5];
        w[4:2]   = sub[2:0];
        w[1]     = sh[5];
        w[0]     = rc[0];
        return w;
    endfunction

    function automatic exp_t model(input logic iss, input logic [31:0] w,
                                   input logic [63:0] s, input logic [63:0] o,
                                   input logic m32, input logic sov);
        exp_t e;
        int sub = int'(w[4:2]);
        int sh  = int'({w[1], w[15:11]});
        int fld = int'({w[5], w[10:6]});
        int b = 0, f = 63;
        logic [63:0] rot = '0, msk = '0;
        bit legal = (w[31:26] == 6'd30) && (sub == 0 || sub == 1 || sub == 3);
        e.wr = 0; e.flt = 0; e.rec = 0; e.cr = 0; e.res = 0;
        e.src = w[25:21]; e.dst = w[20:16]; e.tag = "R3";
        if (!iss) return e;
        if (m32 || !legal) begin
            e.flt = 1;
            e.tag = m32 ? "R9" : "R8";
            return e;
        end
        for (int i = 0; i < 64; i++) rot[(i + sh) % 64] = s[i];
        if (sub == 0) begin b = fld; f = 63; e.tag = "R4"; end
        else if (sub == 1) begin b = 0; f = fld; e.tag = "R5"; end
        else begin b = fld; f = 63 - sh; e.tag = "R6"; end
        if (b > f) e.tag = "R7";
        for (int m = 0; m < 64; m++) begin
            if (b <= f) msk[63 - m] = (m >= b && m <= f);
            else        msk[63 - m] = (m >= b || m <= f);
        end
        e.res = (sub == 3) ? ((rot & msk) | (o & ~msk)) : (rot & msk);
        e.wr = 1;
        e.rec = w[0];
        if (w[0]) begin
            e.cr[3] = ($signed(e.res) < 0);
            e.cr[2] = ($signed(e.res) > 0);
            e.cr[1] = (e.res == 0);
            e.cr[0] = sov;
        end
        return e;
    endfunction

    task automatic chk1(input string tag, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk1(e.tag, "result", result, e.res);
        chk1(e.wr ? "R3" : e.tag, "wr_en", 64'(wr_en), 64'(e.wr));
        chk1(e.flt ? e.tag : "R8", "fault", 64'(fault), 64'(e.flt));
        chk1("R10", "rec_flag", 64'(rec_flag), 64'(e.rec));
        chk1("R10", "cr0", 64'(cr0), 64'(e.cr));
        chk1("R2", "src_idx", 64'(src_idx), 64'(e.src));
        chk1("R2", "dst_idx", 64'(dst_idx), 64'(e.dst));
    endtask

    task automatic step(input logic iss, input logic [31:0] w,
                        input logic [63:0] s, input logic [63:0] o,
                        input logic m32, input logic sov);
        @(negedge clk);
        if (have_pend) compare(pend);
        issue = iss; insn = w; src_val = s; dst_old = o;
        mode32 = m32; so_in = sov;
        pend = model(iss, w, s, o, m32, sov);
        have_pend = 1;
    endtask

    task automatic check_quiet(input string tag);
        chk1(tag, "wr_en", 64'(wr_en), 64'd0);
        chk1(tag, "fault", 64'(fault), 64'd0);
        chk1(tag, "rec_flag", 64'(rec_flag), 64'd0);
        chk1(tag, "cr0", 64'(cr0), 64'd0);
        chk1(tag, "result", result, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R1");          // R1: outputs quiet during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");          // R1: quiet after release, no issue

        // R4 clear-left: identity, then high shift with upper bound bit
        step(1, mk(0, 0, 0, 3, 4, 0), 64'h0123_4567_89ab_cdef, 0, 0, 0);
        step(1, mk(0, 63, 32, 1, 2, 0), 64'h8000_0000_0000_0001, 0, 0, 0);
        step(1, mk(0, 33, 5, 7, 9, 1), 64'hfedc_ba98_7654_3210, 0, 0, 0);
        // R5 clear-right
        step(1, mk(1, 0, 0, 5, 6, 1), 64'hffff_ffff_ffff_ffff, 0, 0, 1);
        step(1, mk(1, 1, 63, 8, 10, 0), 64'h8000_0000_0000_0000, 0, 0, 0);
        step(1, mk(1, 40, 20, 31, 30, 1), 64'h0000_0000_ffff_0000, 0, 0, 0);
        // R6 insert, R7 wrap
        step(1, mk(3, 8, 0, 2, 3, 0), 64'h1122_3344_5566_7788, 64'haaaa_aaaa_aaaa_aaaa, 0, 0);
        step(1, mk(3, 0, 63, 2, 3, 1), 64'h0000_0000_0000_0001, 64'h5555_5555_5555_5554, 0, 0);
        step(1, mk(3, 8, 60, 4, 5, 0), 64'hffff_ffff_ffff_ffff, 64'h0, 0, 0);
        step(1, mk(3, 32, 48, 4, 5, 1), 64'h0123_4567_89ab_cdef, 64'hffff_0000_ffff_0000, 0, 1);
        // R10 record: zero result
        step(1, mk(0, 0, 0, 1, 1, 1), 64'h0, 0, 0, 1);
        // R8 bad sub-opcodes and bad primary field
        step(1, mk(2, 5, 5, 1, 1, 1), 64'h1234, 0, 0, 0);
        step(1, mk(7, 5, 5, 1, 1, 1), 64'h1234, 0, 0, 0);
        step(1, mk(0, 5, 5, 1, 1, 1) ^ 32'h0400_0000, 64'h1234, 0, 0, 0);
        // R9 32-bit mode
        step(1, mk(0, 4, 4, 1, 1, 1), 64'h1234, 0, 1, 0);
        step(1, mk(3, 4, 4, 1, 1, 0), 64'h1234, 64'h99, 1, 0);
        // R3 idle gaps
        step(0, mk(0, 4, 4, 9, 9, 1), 64'h1234, 0, 0, 0);
        step(0, 32'h0, 64'h0, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 9);
            int sub = (r < 3) ? 0 : (r < 6) ? 1 : (r < 9) ? 3 : $urandom_range(0, 7);
            logic [31:0] w = mk(sub, $urandom_range(0, 63), $urandom_range(0, 63),
                                $urandom_range(0, 31), $urandom_range(0, 31),
                                $urandom_range(0, 1));
            step(($urandom_range(0, 7) != 0), w, {$urandom, $urandom},
                 {$urandom, $urandom}, ($urandom_range(0, 15) == 0),
                 $urandom_range(0, 1) == 1);
        end
        step(0, 32'h0, 64'h0, 0, 0, 0);
        step(0, 32'h0, 64'h0, 0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule